// File: doc/BRIEF.md
# Wrapping Transfer Address Incrementer

This block advances the transfer address held by a debug memory-access port after each data-register access. When a bus transfer completes, it works out the next address from the current address, the access size and the increment mode. It then raises a one-cycle load enable so the address register can take that value.

The increment stays inside a 4 KB window: only the low twelve address bits count, and they roll over from the top of the window back to its base. The upper bits are left as they are. No increment happens in any of these cases:

- the transfer ended with an error;
- the access went to one of the banked data registers;
- the mode is off or reserved;
- the size code is reserved.

The same block also produces the byte-lane strobes for the transfer that is under way. It derives them combinationally from the current address, size, mode and access type.

Top module: `wrap_addr_incr`

## Requirements
- R1: On a load, the new address equals the current address aligned to the access size plus a step of 1, 2 or 4 bytes for size codes 0 (byte), 1 (halfword) and 2 (word).
- R2: Address bits [31:12] on `next_addr` equal those of the current address; bits [11:0] wrap modulo 4096 (word step from 0x1FFC gives 0x1000; 1023 word steps from 0x14A0 give 0x149C).
- R3: `addr_load` is raised only for a completed transfer (`xfer_done`=1) with `xfer_err`=0. When no load happens, `next_addr` keeps its previous value.
- R4: A banked access (`banked_acc`=1) never loads, whatever the mode. Its strobes are 4'b1111, because banked accesses are treated as word accesses.
- R5: Mode code 2'b00 (off) gives no load but valid strobes. Mode code 2'b11 (reserved) gives no load and strobes 4'b0000. Codes 2'b01 (single) and 2'b10 (packed) allow a load.
- R6: Size codes 3 to 7 are reserved: no load, and strobes 4'b0000.
- R7: For byte size the strobes are 4'b0001 shifted left by `cur_addr[1:0]`.
- R8: For halfword size the strobes are 4'b0011 shifted left by 2 × `cur_addr[1]`.
- R9: For word size the strobes are 4'b1111.
- R10: Before the step is added, the low address bits below the access size are cleared (halfword at 0x1003 gives 0x1004; word at 0x1003 gives 0x1004).
- R11: `addr_load` and the new `next_addr` appear in the clock cycle after the one in which `xfer_done` is sampled. `addr_load` lasts exactly one cycle per completion.
- R12: After reset, `addr_load` is 0 and `next_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cur_addr | input | 32 | Current transfer address |
| size_code | input | 3 | Access size code |
| step_mode | input | 2 | Increment mode: 00 off, 01 single, 10 packed, 11 reserved |
| banked_acc | input | 1 | Access targets a banked data register |
| xfer_done | input | 1 | Bus transfer completed this cycle |
| xfer_err | input | 1 | Completed transfer returned an error |
| next_addr | output | 32 | Incremented address to load |
| addr_load | output | 1 | Load enable for the address register |
| byte_strb | output | 4 | Byte-lane strobes for the current access |

## Verification
The assertions watch the following on every cycle:

- that each load traces back to an error-free completion on a non-banked access;
- that the mode and size codes were legal for that load;
- that the upper address bits survive the load;
- that the load pulse never appears without a completion;
- that the byte and halfword strobes have the right number of lanes.

Some behaviour only the bench scenarios can show:

- the exact wrapped value, including the 1023-step sweep from 0x14A0 that returns to just below its start;
- the alignment of odd addresses;
- the lane position of each strobe;
- the fact that `next_addr` keeps its value when a load is suppressed.

// File: rtl/wai_pkg.sv
package wai_pkg;

    // Increment mode encoding shared by the gate and the top level
    typedef enum logic [1:0] {
        STEP_OFF    = 2'b00,
        STEP_SINGLE = 2'b01,
        STEP_PACKED = 2'b10,
        STEP_RSVD   = 2'b11
    } step_mode_e;

    // Size code width; the code value is log2 of the access byte count
    localparam int SIZE_W = 3;

endpackage

// File: rtl/wai_incr_gate.sv
module wai_incr_gate
    import wai_pkg::*;
#(
    parameter int LANE_W = 2
) (
    input  logic [1:0]        step_mode,
    input  logic [SIZE_W-1:0] size_code,
    input  logic              banked_acc,
    input  logic              xfer_done,
    input  logic              xfer_err,
    output logic              size_ok,
    output logic              xfer_ok,
    output logic              inc_en
);

    step_mode_e mode_e;
    logic       mode_steps;

    always_comb begin
        mode_e     = step_mode_e'(step_mode);
        // Sizes wider than the data path are reserved
        size_ok    = (size_code <= SIZE_W'(LANE_W));
        // The reserved mode issues no transfer at all
        xfer_ok    = (mode_e != STEP_RSVD);
        mode_steps = (mode_e == STEP_SINGLE) || (mode_e == STEP_PACKED);
        inc_en     = xfer_done && !xfer_err && !banked_acc
                     && mode_steps && size_ok;
    end

endmodule

// File: rtl/wai_step_adder.sv
module wai_step_adder
    import wai_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int WIN_BITS = 12,
    parameter int LANE_W   = 2
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [SIZE_W-1:0] size_code,
    input  logic              size_ok,
    output logic [ADDR_W-1:0] stepped_addr
);

    logic [SIZE_W-1:0]   size_eff;
    logic [WIN_BITS-1:0] step_w;
    logic [WIN_BITS-1:0] low_aligned;
    logic [WIN_BITS-1:0] low_next;

    always_comb begin
        // A reserved size never loads; clamp so the shift stays bounded
        size_eff     = size_ok ? size_code : SIZE_W'(LANE_W);
        step_w       = WIN_BITS'(1) << size_eff;
        // Clear the bits below the access size, then add the step
        low_aligned  = cur_addr[WIN_BITS-1:0] & ~(step_w - WIN_BITS'(1));
        // The sum is truncated to the window width, which gives the wrap
        low_next     = low_aligned + step_w;
        stepped_addr = {cur_addr[ADDR_W-1:WIN_BITS], low_next};
    end

endmodule

// File: rtl/wai_lane_strobe.sv
module wai_lane_strobe
    import wai_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int LANE_W = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LANE_W-1:0] lane_addr,
    input  logic [SIZE_W-1:0] size_code,
    input  logic              size_ok,
    input  logic              xfer_ok,
    input  logic              banked_acc,
    output logic [LANES-1:0]  strb
);

    logic [SIZE_W-1:0] size_eff;
    logic [LANE_W:0]   span;
    logic [LANE_W-1:0] base;
    logic [LANES-1:0]  hit;

    always_comb begin
        size_eff = size_ok ? size_code : SIZE_W'(0);
        span     = (LANE_W+1)'(1) << size_eff;
        // First lane of the aligned access
        base     = lane_addr & ~LANE_W'(span - (LANE_W+1)'(1));
    end

    // One comparator pair per byte lane
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign hit[g] = (g >= int'(base)) && (g < int'(base) + int'(span));
    end

    always_comb begin
        if (banked_acc)
            strb = '1;
        else if (xfer_ok && size_ok)
            strb = hit;
        else
            strb = '0;
    end

    // R7
    byte_one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!banked_acc && xfer_ok && size_code == SIZE_W'(0)) |-> $countones(strb) == 1);

    // R8
    half_two_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!banked_acc && xfer_ok && size_code == SIZE_W'(1)) |-> $countones(strb) == 2);

endmodule

// File: rtl/wrap_addr_incr.sv
module wrap_addr_incr
    import wai_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int WIN_BITS = 12,
    parameter int LANES    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [SIZE_W-1:0] size_code,
    input  logic [1:0]        step_mode,
    input  logic              banked_acc,
    input  logic              xfer_done,
    input  logic              xfer_err,
    output logic [ADDR_W-1:0] next_addr,
    output logic              addr_load,
    output logic [LANES-1:0]  byte_strb
);

    localparam int LANE_W = $clog2(LANES);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              load;
    } incr_state_t;

    incr_state_t       st_d, st_q;
    logic              size_ok, xfer_ok, inc_en;
    logic [ADDR_W-1:0] stepped_addr;

    wai_incr_gate #(.LANE_W(LANE_W)) u_gate (
        .step_mode  (step_mode),
        .size_code  (size_code),
        .banked_acc (banked_acc),
        .xfer_done  (xfer_done),
        .xfer_err   (xfer_err),
        .size_ok    (size_ok),
        .xfer_ok    (xfer_ok),
        .inc_en     (inc_en)
    );

    wai_step_adder #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .LANE_W(LANE_W)) u_adder (
        .cur_addr     (cur_addr),
        .size_code    (size_code),
        .size_ok      (size_ok),
        .stepped_addr (stepped_addr)
    );

    wai_lane_strobe #(.LANES(LANES), .LANE_W(LANE_W)) u_strobe (
        .clk        (clk),
        .rst_n      (rst_n),
        .lane_addr  (cur_addr[LANE_W-1:0]),
        .size_code  (size_code),
        .size_ok    (size_ok),
        .xfer_ok    (xfer_ok),
        .banked_acc (banked_acc),
        .strb       (byte_strb)
    );

    always_comb begin
        st_d      = st_q;
        st_d.load = inc_en;
        if (inc_en)
            st_d.addr = stepped_addr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign next_addr = st_q.addr;
    assign addr_load = st_q.load;

    // R3
    load_after_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_load |-> $past(xfer_done && !xfer_err));

    // R4
    banked_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_load |-> !$past(banked_acc));

    // R5
    mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_load |-> ($past(step_mode) == 2'b01 || $past(step_mode) == 2'b10));

    // R6
    size_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_load |-> $past(size_code) <= SIZE_W'(LANE_W));

    // R2
    upper_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_load |-> next_addr[ADDR_W-1:WIN_BITS] == $past(cur_addr[ADDR_W-1:WIN_BITS]));

    // R11
    pulse_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(xfer_done) |-> !addr_load);

endmodule

// File: tb/wrap_addr_incr_test.sv
`timescale 1ns/1ps
module wrap_addr_incr_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cur_addr = '0;
    logic [2:0]  size_code = '0;
    logic [1:0]  step_mode = '0;
    logic        banked_acc = 1'b0;
    logic        xfer_done = 1'b0;
    logic        xfer_err = 1'b0;
    logic [31:0] next_addr;
    logic        addr_load;
    logic [3:0]  byte_strb;

    int          checks = 0;
    int          errors = 0;
    logic [31:0] held = '0;

    always #2 clk = ~clk;

    wrap_addr_incr uut (
        .clk(clk), .rst_n(rst_n), .cur_addr(cur_addr), .size_code(size_code),
        .step_mode(step_mode), .banked_acc(banked_acc), .xfer_done(xfer_done),
        .xfer_err(xfer_err), .next_addr(next_addr), .addr_load(addr_load),
        .byte_strb(byte_strb)
    );

    function automatic logic [31:0] exp_next(logic [31:0] a, logic [2:0] sz);
        int unsigned bytes = 1 << sz;
        int unsigned base  = a[11:0] - (a[11:0] % bytes);
        logic [11:0] low   = 12'((base + bytes) % 4096);
        return {a[31:12], low};
    endfunction

    function automatic logic exp_load(logic d, logic e, logic [1:0] m,
                                      logic [2:0] sz, logic b);
        return d && !e && !b && (m == 2'b01 || m == 2'b10) && sz <= 3'd2;
    endfunction

    function automatic logic [3:0] exp_strb(logic [31:0] a, logic [2:0] sz,
                                            logic [1:0] m, logic b);
        if (b) return 4'hF;
        if (m == 2'b11 || sz > 3'd2) return 4'h0;
        case (sz)
            3'd0:    return 4'b0001 << a[1:0];
            3'd1:    return a[1] ? 4'b1100 : 4'b0011;
            default: return 4'hF;
        endcase
    endfunction

    task automatic check(logic ok, string req, string what,
                         logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic apply(logic [31:0] a, logic [2:0] sz, logic [1:0] m,
                         logic b, logic d, logic e);
        string       stag;
        logic [3:0]  es;
        logic        el;
        @(negedge clk);
        // previous pulse must have ended (R11)
        check(addr_load == 1'b0, "R11", "load pulse length", 32'(addr_load), 32'h0);
        cur_addr = a; size_code = sz; step_mode = m; banked_acc = b;
        xfer_done = d; xfer_err = e;
        #1;
        es = exp_strb(a, sz, m, b);
        if (b)               stag = "R4";
        else if (m == 2'b11) stag = "R5";
        else if (sz > 3'd2)  stag = "R6";
        else if (sz == 3'd0) stag = "R7";
        else if (sz == 3'd1) stag = "R8";
        else                 stag = "R9";
        check(byte_strb == es, stag, "strobes", 32'(byte_strb), 32'(es));
        el = exp_load(d, e, m, sz, b);
        if (el) held = exp_next(a, sz);
        @(negedge clk);
        check(addr_load == el, "R3", "load enable", 32'(addr_load), 32'(el));
        check(next_addr == held, "R1", "next address", next_addr, held);
        xfer_done = 1'b0;
        xfer_err  = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] a;
        void'($urandom(32'h5eed_0042));
        repeat (3) @(negedge clk);
        // R12 reset state
        check(addr_load == 1'b0, "R12", "reset load", 32'(addr_load), 32'h0);
        check(next_addr == 32'h0, "R12", "reset address", next_addr, 32'h0);
        rst_n = 1'b1;

        // R2 wrap at top of window, upper bits kept
        apply(32'h0000_1FFC, 3'd2, 2'b01, 0, 1, 0);
        check(next_addr == 32'h0000_1000, "R2", "word wrap", next_addr, 32'h1000);
        apply(32'hABCD_EFFF, 3'd0, 2'b10, 0, 1, 0);
        check(next_addr == 32'hABCD_E000, "R2", "byte wrap", next_addr, 32'hABCDE000);
        // R10 alignment before step
        apply(32'h0000_1003, 3'd1, 2'b01, 0, 1, 0);
        check(next_addr == 32'h0000_1004, "R10", "half align", next_addr, 32'h1004);
        apply(32'h0000_1003, 3'd2, 2'b01, 0, 1, 0);
        check(next_addr == 32'h0000_1004, "R10", "word align", next_addr, 32'h1004);
        apply(32'h7777_2FFF, 3'd1, 2'b10, 0, 1, 0);
        check(next_addr == 32'h7777_2000, "R10", "half align wrap", next_addr, 32'h77772000);
        // R3 error and missing completion; R11 no done no load
        apply(32'h0000_0100, 3'd2, 2'b01, 0, 1, 1);
        apply(32'h0000_0200, 3'd2, 2'b01, 0, 0, 0);
        // R4 banked, any mode
        for (int m = 0; m < 4; m++) apply(32'h0000_0310, 3'd0, 2'(m), 1, 1, 0);
        // R5 off and reserved mode
        apply(32'h0000_0402, 3'd0, 2'b00, 0, 1, 0);
        apply(32'h0000_0404, 3'd2, 2'b11, 0, 1, 0);
        // R6 reserved sizes
        for (int s = 3; s < 8; s++) apply(32'h0000_0500, 3'(s), 2'b01, 0, 1, 0);
        // R7 R8 R9 every lane offset
        for (int s = 0; s < 3; s++)
            for (int o = 0; o < 4; o++) apply(32'h0000_0600 + 32'(o), 3'(s), 2'b01, 0, 1, 0);

        // R2 full sweep from 0x14A0 round the window
        a = 32'h5555_14A0;
        for (int i = 0; i < 1023; i++) begin
            apply(a, 3'd2, 2'b01, 0, 1, 0);
            a = exp_next(a, 3'd2);
        end
        check(next_addr == 32'h5555_149C, "R2", "sweep end", next_addr, 32'h5555149C);

        // Random mix
        for (int i = 0; i < 400; i++) begin
            logic [2:0] sz = ($urandom % 4 == 0) ? 3'($urandom) : 3'($urandom % 3);
            apply($urandom, sz, 2'($urandom), ($urandom % 5) == 0,
                  ($urandom % 6) != 0, ($urandom % 5) == 0);
        end

        @(negedge clk);
        check(addr_load == 1'b0, "R11", "final idle", 32'(addr_load), 32'h0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule